// File: doc/BRIEF.md
# Buffered Slave Core Wrapper

This block sits between a network interface and a slave coprocessor that handles data one block at a time. Network writes into small numbered configuration registers set the coprocessor's static pins: block length, physical mode, code rate, iteration limit, early-stop threshold and an early-stop enable. Input payload arrives as 64-bit flits and is queued in an input FIFO. An unpacker then hands the queued flits to the core as 16-bit samples, with a sample-enable strobe and a block-start marker.

In the other direction, the core returns 2-bit results. These are gathered into 64-bit flits and queued in an output FIFO that the network side drains. When the last result of a block has been taken, any partly filled flit is padded with zeros and queued. A one-cycle completion pulse then tells the network interface how many flits to send. At the same moment, the core's reported effective iteration count is latched into a status register.

Top module: `slave_core_wrapper`

## Requirements
- R1: After reset, every configuration pin, `eff_iter`, `done`, `out_valid` and `core_den` are 0, and `in_ready` and `core_qrdy` are 1.
- R2: A write with `cfg_sel`=1 loads `blk_len` from `cfg_wdata[15:0]`. `cfg_sel`=2 loads `phy_mode`=[1:0], `code_rate`=[4:2] and `max_iter`=[9:5]. `cfg_sel`=3 loads `stop_thresh`=[7:0] and `dyn_stop`=[8]. Pins change on the clock edge of the write.
- R3: A write with `cfg_sel`=0 changes no configuration pin, and pins hold their value in cycles without a write.
- R4: Samples leave each flit lowest 16 bits first: sample k of a block is bits [16(k mod 4)+15 : 16(k mod 4)] of flit k/4. `core_den` is high only while `core_drdy` is high and a flit is queued, and `core_d` is valid in that cycle.
- R5: `core_dblk` is high together with the first sample of each block, and at no other time.
- R6: When a block ends part-way through a flit, the unused lanes of that flit are discarded. The next block starts at lane 0 of the next flit.
- R7: A result is taken in a cycle with `core_qen` and `core_qrdy` both high. The j-th result within a flit goes to bits [2j+1:2j]. `core_qrdy` is low exactly when the output FIFO holds OUT_DEPTH flits.
- R8: Each block yields ceil(`blk_len`/32) output flits, in order. The last flit of a block is zero-padded above its final result, and no extra flit is produced when `blk_len` is a multiple of 32.
- R9: `done` is a one-cycle pulse in the cycle after the block's last result is taken, with `xfer_flits` = ceil(`blk_len`/32).
- R10: `eff_iter` takes the value of `core_effit` from the cycle of the block's last result, becomes visible together with `done`, and holds at all other times.
- R11: `in_ready` is low exactly when the input FIFO holds IN_DEPTH flits, and queued flits are consumed in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write value |
| in_valid | input | 1 | Input flit offered |
| in_flit | input | 64 | Input flit |
| in_ready | output | 1 | Input FIFO can accept a flit |
| core_drdy | input | 1 | Core can take a sample |
| core_d | output | 16 | Sample to core |
| core_den | output | 1 | Sample valid |
| core_dblk | output | 1 | First sample of a block |
| core_q | input | 2 | Result from core |
| core_qen | input | 1 | Result valid |
| core_qrdy | output | 1 | Wrapper can take a result |
| core_effit | input | 5 | Core's effective iteration count |
| blk_len | output | 16 | Block length pin |
| phy_mode | output | 2 | Physical mode pin |
| code_rate | output | 3 | Code rate pin |
| max_iter | output | 5 | Iteration limit pin |
| stop_thresh | output | 8 | Early-stop threshold pin |
| dyn_stop | output | 1 | Early-stop enable pin |
| out_pop | input | 1 | Network side takes the head output flit |
| out_valid | output | 1 | Output flit available |
| out_flit | output | 64 | Head output flit |
| done | output | 1 | Block finished; result transfer request |
| xfer_flits | output | 12 | Flit count of the transfer |
| eff_iter | output | 5 | Latched effective iteration count |

## Verification
Two functions can land on the same edge: the end-of-block flush pushes the padded last flit, while the drain side pops an earlier flit. The ingest side can likewise push a flit in the same cycle the unpacker pops one. Random pop and ready enables, together with deliberately stalled phases that fill both FIFOs, force these collisions. They are judged by modelling each FIFO's occupancy from counted pushes and pops, and by comparing every flit that leaves against a bench-packed expectation.

// File: rtl/scw_pkg.sv
package scw_pkg;
    localparam int FLIT_W  = 64;
    localparam int WORD_W  = 16;
    localparam int RES_W   = 2;
    localparam int LEN_W   = 16;
    localparam int EFF_W   = 5;
    localparam int LANES   = FLIT_W / WORD_W;
    localparam int SLOTS   = FLIT_W / RES_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int XFER_W  = LEN_W - SLOT_W + 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_MODE = 2'd2,
        SEL_STOP = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [1:0]       phy;
        logic [2:0]       rate;
        logic [4:0]       iters;
        logic [7:0]       thresh;
        logic             dstop;
    } core_cfg_t;

    function automatic logic [XFER_W-1:0] flits_for(input logic [LEN_W-1:0] n);
        logic [LEN_W:0] t;
        t = {1'b0, n} + (LEN_W+1)'(SLOTS - 1);
        return XFER_W'(t >> SLOT_W);
    endfunction
endpackage

// File: rtl/scw_fifo.sv
module scw_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)); // R11
endmodule

// File: rtl/scw_unpacker.sv
module scw_unpacker
    import scw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLIT_W-1:0] flit,
    input  logic              flit_avail,
    input  logic              drdy,
    input  logic [LEN_W-1:0]  len,
    output logic              flit_pop,
    output logic [WORD_W-1:0] d,
    output logic              den,
    output logic              dblk
);
    logic [WORD_W-1:0] lane_word [LANES];
    logic [LANE_W-1:0] lane;
    logic [LEN_W-1:0]  wcnt;
    logic              last_word, last_lane;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_word[g] = flit[g*WORD_W +: WORD_W];
    end

    assign den       = flit_avail && drdy;
    assign d         = lane_word[lane];
    assign last_word = (wcnt == len - 1'b1);
    assign last_lane = (lane == LANE_W'(LANES - 1));
    assign flit_pop  = den && (last_lane || last_word);
    assign dblk      = den && (wcnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane <= '0;
            wcnt <= '0;
        end else if (den) begin
            lane <= flit_pop ? '0 : lane + 1'b1;
            wcnt <= last_word ? '0 : wcnt + 1'b1;
        end
    end

    AST_EN_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
        den |-> drdy); // R4
    AST_START_ONCE: assert property (@(posedge clk) disable iff (rst)
        (dblk && len != 16'd1 && $stable(len)) |=> !dblk); // R5
endmodule

// File: rtl/scw_packer.sv
module scw_packer
    import scw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RES_W-1:0]  q,
    input  logic              qen,
    input  logic              room,
    input  logic [LEN_W-1:0]  len,
    input  logic [EFF_W-1:0]  effit,
    output logic              qrdy,
    output logic              push,
    output logic [FLIT_W-1:0] pflit,
    output logic              done,
    output logic [XFER_W-1:0] xfer,
    output logic [EFF_W-1:0]  status
);
    logic [FLIT_W-1:0] acc, nxt;
    logic [SLOT_W-1:0] slot;
    logic [LEN_W-1:0]  rcnt;
    logic              take, last_res, slot_full;

    assign qrdy      = room;
    assign take      = qen && room;
    assign last_res  = (rcnt == len - 1'b1);
    assign slot_full = (slot == SLOT_W'(SLOTS - 1));
    assign push      = take && (slot_full || last_res);
    assign pflit     = nxt;

    always_comb begin
        nxt = acc;
        nxt[RES_W*int'(slot) +: RES_W] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            slot   <= '0;
            rcnt   <= '0;
            done   <= 1'b0;
            xfer   <= '0;
            status <= '0;
        end else begin
            done <= take && last_res;
            if (take) begin
                acc  <= push ? '0 : nxt;
                slot <= push ? '0 : slot + 1'b1;
                rcnt <= last_res ? '0 : rcnt + 1'b1;
                if (last_res) begin
                    xfer   <= flits_for(len);
                    status <= effit;
                end
            end
        end
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(qen && room)); // R9
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(status)); // R10
    AST_QRDY_ROOM: assert property (@(posedge clk) disable iff (rst)
        push |-> qrdy); // R7
endmodule

// File: rtl/slave_core_wrapper.sv
module slave_core_wrapper
    import scw_pkg::*;
#(
    parameter int IN_DEPTH  = 8,
    parameter int OUT_DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [15:0]  cfg_wdata,
    input  logic         in_valid,
    input  logic [63:0]  in_flit,
    output logic         in_ready,
    input  logic         core_drdy,
    output logic [15:0]  core_d,
    output logic         core_den,
    output logic         core_dblk,
    input  logic [1:0]   core_q,
    input  logic         core_qen,
    output logic         core_qrdy,
    input  logic [4:0]   core_effit,
    output logic [15:0]  blk_len,
    output logic [1:0]   phy_mode,
    output logic [2:0]   code_rate,
    output logic [4:0]   max_iter,
    output logic [7:0]   stop_thresh,
    output logic         dyn_stop,
    input  logic         out_pop,
    output logic         out_valid,
    output logic [63:0]  out_flit,
    output logic         done,
    output logic [11:0]  xfer_flits,
    output logic [4:0]   eff_iter
);
    core_cfg_t         cfg_q;
    logic              in_full, in_empty, in_pop;
    logic [FLIT_W-1:0] in_head;
    logic              out_full, out_empty, out_push;
    logic [FLIT_W-1:0] out_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_LEN:  cfg_q.len <= cfg_wdata;
                SEL_MODE: begin
                    cfg_q.phy   <= cfg_wdata[1:0];
                    cfg_q.rate  <= cfg_wdata[4:2];
                    cfg_q.iters <= cfg_wdata[9:5];
                end
                SEL_STOP: begin
                    cfg_q.thresh <= cfg_wdata[7:0];
                    cfg_q.dstop  <= cfg_wdata[8];
                end
                default: ;
            endcase
        end
    end

    assign blk_len     = cfg_q.len;
    assign phy_mode    = cfg_q.phy;
    assign code_rate   = cfg_q.rate;
    assign max_iter    = cfg_q.iters;
    assign stop_thresh = cfg_q.thresh;
    assign dyn_stop    = cfg_q.dstop;

    scw_fifo #(.W(FLIT_W), .DEPTH(IN_DEPTH)) u_in_fifo (
        .clk(clk), .rst(rst), .push(in_valid), .wdata(in_flit),
        .pop(in_pop), .rdata(in_head), .full(in_full), .empty(in_empty)
    );
    assign in_ready = !in_full;

    scw_unpacker u_unpack (
        .clk(clk), .rst(rst), .flit(in_head), .flit_avail(!in_empty),
        .drdy(core_drdy), .len(cfg_q.len), .flit_pop(in_pop),
        .d(core_d), .den(core_den), .dblk(core_dblk)
    );

    scw_packer u_pack (
        .clk(clk), .rst(rst), .q(core_q), .qen(core_qen), .room(!out_full),
        .len(cfg_q.len), .effit(core_effit), .qrdy(core_qrdy),
        .push(out_push), .pflit(out_wr), .done(done), .xfer(xfer_flits),
        .status(eff_iter)
    );

    scw_fifo #(.W(FLIT_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
        .clk(clk), .rst(rst), .push(out_push), .wdata(out_wr),
        .pop(out_pop), .rdata(out_flit), .full(out_full), .empty(out_empty)
    );
    assign out_valid = !out_empty;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q)); // R3
    AST_IDLE_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd0) |=> $stable(cfg_q)); // R3
endmodule

// File: tb/slave_core_wrapper_tb.sv
module slave_core_wrapper_tb;
    localparam int IN_DEPTH  = 8;
    localparam int OUT_DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [63:0] in_flit = '0;
    logic        in_ready;
    logic        core_drdy = 1'b0;
    logic [15:0] core_d;
    logic        core_den, core_dblk;
    logic [1:0]  core_q = '0;
    logic        core_qen = 1'b0;
    logic        core_qrdy;
    logic [4:0]  core_effit = '0;
    logic [15:0] blk_len;
    logic [1:0]  phy_mode;
    logic [2:0]  code_rate;
    logic [4:0]  max_iter;
    logic [7:0]  stop_thresh;
    logic        dyn_stop;
    logic        out_pop = 1'b0;
    logic        out_valid;
    logic [63:0] out_flit;
    logic        done;
    logic [11:0] xfer_flits;
    logic [4:0]  eff_iter;

    int checks = 0;
    int errors = 0;
    int seed_dummy;

    always #4 clk = ~clk;

    slave_core_wrapper #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .core_drdy(core_drdy), .core_d(core_d), .core_den(core_den), .core_dblk(core_dblk),
        .core_q(core_q), .core_qen(core_qen), .core_qrdy(core_qrdy), .core_effit(core_effit),
        .blk_len(blk_len), .phy_mode(phy_mode), .code_rate(code_rate), .max_iter(max_iter),
        .stop_thresh(stop_thresh), .dyn_stop(dyn_stop), .out_pop(out_pop),
        .out_valid(out_valid), .out_flit(out_flit), .done(done),
        .xfer_flits(xfer_flits), .eff_iter(eff_iter)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [33:0] cfg_image();
        return {blk_len, phy_mode, code_rate, max_iter, stop_thresh, dyn_stop};
    endfunction

    task automatic write_cfg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    endtask

    task automatic run_block(input int n, input int stall_in, input int hold_out);
        int nfl, nfo, pi, wi, ri, fi, dn, cyc, popped_in, pushed_out, occ;
        logic [63:0] fl [64];
        logic [1:0]  er [256];
        logic [63:0] ef;
        logic [4:0]  eff;
        nfl = (n + 3) / 4;
        nfo = (n + 31) / 32;
        pi = 0; wi = 0; ri = 0; fi = 0; dn = 0; cyc = 0;
        write_cfg(2'd1, 16'(n));
        for (int i = 0; i < nfl; i++) fl[i] = {$urandom, $urandom};
        for (int i = 0; i < n; i++) er[i] = 2'($urandom);
        eff = 5'($urandom);
        while (!(wi == n && ri == n && fi == nfo && dn == 1) && cyc < 6000) begin
            @(negedge clk);
            in_valid   = (pi < nfl);
            in_flit    = (pi < nfl) ? fl[pi] : '0;
            core_drdy  = (cyc >= stall_in) && ($urandom % 4 != 0);
            core_qen   = (ri < n) && ($urandom % 3 != 0);
            core_q     = (ri < n) ? er[ri] : 2'd0;
            core_effit = (ri == n - 1) ? eff : 5'($urandom);
            out_pop    = (cyc >= hold_out) && ($urandom % 3 != 0);
            #1;
            popped_in = (wi == n) ? nfl : wi / 4;
            occ = pi - popped_in;
            chk(in_ready == (occ < IN_DEPTH), "R11 in_ready", 64'(in_ready), 64'(occ < IN_DEPTH));
            if (in_valid && in_ready) pi++;
            if (core_den) begin
                chk(core_drdy == 1'b1, "R4 den without drdy", 64'(core_drdy), 64'd1);
                chk(core_d == fl[wi/4][16*(wi%4) +: 16], "R4/R6 sample", 64'(core_d), 64'(fl[wi/4][16*(wi%4) +: 16]));
                chk(core_dblk == (wi == 0), "R5 block start", 64'(core_dblk), 64'(wi == 0));
                wi++;
            end else begin
                chk(core_dblk == 1'b0, "R5 idle dblk", 64'(core_dblk), 64'd0);
            end
            pushed_out = (ri == n) ? nfo : ri / 32;
            occ = pushed_out - fi;
            chk(core_qrdy == (occ < OUT_DEPTH), "R7 qrdy", 64'(core_qrdy), 64'(occ < OUT_DEPTH));
            chk(out_valid == (occ > 0), "R8 flit count", 64'(out_valid), 64'(occ > 0));
            if (core_qen && core_qrdy) ri++;
            if (out_valid && out_pop) begin
                ef = '0;
                for (int j = 0; j < 32; j++)
                    if (fi*32 + j < n) ef[2*j +: 2] = er[fi*32 + j];
                chk(out_flit == ef, "R7/R8 packed flit", out_flit, ef);
                fi++;
            end
            if (done) begin
                chk(dn == 0 && ri == n, "R9 done timing", 64'(dn), 64'd0);
                chk(xfer_flits == 12'(nfo), "R9 xfer_flits", 64'(xfer_flits), 64'(nfo));
                chk(eff_iter == eff, "R10 eff_iter capture", 64'(eff_iter), 64'(eff));
                dn++;
            end
            cyc++;
        end
        chk(cyc < 6000, "R8 block completion", 64'(cyc), 64'd6000);
        @(negedge clk);
        in_valid = 1'b0; core_drdy = 1'b0; core_qen = 1'b0; out_pop = 1'b0;
        core_effit = ~eff;
        #1;
        chk(done == 1'b0, "R9 single pulse", 64'(done), 64'd0);
        @(negedge clk); #1;
        chk(eff_iter == eff, "R10 status hold", 64'(eff_iter), 64'(eff));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [33:0] snap;
        seed_dummy = $urandom(32'h5C0E);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cfg_image() == '0, "R1 config pins", 64'(cfg_image()), 64'd0);
        chk(eff_iter == 0 && done == 0 && out_valid == 0 && core_den == 0, "R1 outputs idle",
            {eff_iter, done, out_valid, core_den}, 64'd0);
        chk(in_ready && core_qrdy, "R1 ready", {in_ready, core_qrdy}, 64'h3);

        write_cfg(2'd2, 16'b0000_0010_1101_1110);
        #1;
        chk(phy_mode == 2'b10, "R2 phy_mode", 64'(phy_mode), 64'h2);
        chk(code_rate == 3'b111, "R2 code_rate", 64'(code_rate), 64'h7);
        chk(max_iter == 5'b10110, "R2 max_iter", 64'(max_iter), 64'h16);
        write_cfg(2'd3, 16'h01A5);
        #1;
        chk(stop_thresh == 8'hA5 && dyn_stop == 1'b1, "R2 stop fields", {stop_thresh, dyn_stop}, {8'hA5, 1'b1});
        write_cfg(2'd1, 16'h1234);
        #1;
        chk(blk_len == 16'h1234, "R2 blk_len", 64'(blk_len), 64'h1234);
        snap = cfg_image();
        write_cfg(2'd0, 16'hFFFF);
        #1;
        chk(cfg_image() == snap, "R3 index 0 ignored", 64'(cfg_image()), 64'(snap));
        repeat (3) @(negedge clk);
        #1;
        chk(cfg_image() == snap, "R3 hold", 64'(cfg_image()), 64'(snap));

        run_block(1, 0, 0);
        run_block(5, 0, 0);
        run_block(5, 0, 0);
        run_block(32, 0, 0);
        run_block(33, 0, 0);
        run_block(40, 30, 0);
        run_block(200, 0, 300);
        run_block(64, 0, 0);
        for (int t = 0; t < 8; t++) run_block(1 + int'($urandom % 250), int'($urandom % 20), int'($urandom % 40));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule